// File: doc/BRIEF.md
# Grouped Single-Active-Input Detector

This block watches a wide input bus and raises one output when exactly one bit of the bus is high. It stays low when the bus is all zero and when two or more bits are high. It is purely combinational and is meant for places such as one-hot checks on select or grant vectors, where a legal state has exactly one line active.

The bus is split into fixed-width groups. Each group is classified by its own first-level unit into one of three states: idle, single, or crowded. Two flags report the state: a "single" flag and a "crowded" flag. Idle is the state in which neither flag is set. A second level takes all group flags. It asserts the result only when exactly one group is single and no group is crowded. When the bus width is not a multiple of the group width, the last group is filled with zeros. The group flags are also brought out as ports so that the group-level classification can be observed.

Top module: `one_hot_detect`

## Requirements
- R1: `exactly_one` is 1 if and only if exactly one bit of `din` is 1, for every input value.
- R2: With `din` all zero, `exactly_one` and every bit of `grp_one` and `grp_many` are 0.
- R3: Two or more 1s inside the same group drive `exactly_one` to 0.
- R4: Group g covers `din[g*M +: M]`. Its `grp_one[g]` is 1 exactly when that slice holds one 1, and its `grp_many[g]` is 1 exactly when the slice holds two or more 1s. The two flags are never both 1.
- R5: Single 1s in two or more different groups drive `exactly_one` to 0, even though no group reports two or more.
- R6: Any group reporting two or more forces `exactly_one` to 0, even when another group reports exactly one.
- R7: The number of groups is ceil(N/M). A partial last group is padded with zeros, so it classifies only its real bits (checked with N=25, M=10).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | N | Bus under test |
| grp_one | output | ceil(N/M) | Per-group flag: the group has exactly one 1 |
| grp_many | output | ceil(N/M) | Per-group flag: the group has two or more 1s |
| exactly_one | output | 1 | High when exactly one bit of `din` is set |

## Verification
Two second-level functions can be true on the same input. One is the rule that a single group reports exactly one. The other is the rule that some group reports two or more. The bench provokes this by placing one 1 in one group and a pair of 1s in another group. The output must then be low, and the two group flags must show one single group and one crowded group at the same time. A second collision pairs single 1s in two separate groups, so that no group is crowded but the second-level counter sees two single groups. The result is judged against a population count of the whole bus.

// File: rtl/ooon_pkg.sv
// Package: shared sizing helpers for the grouped single-active detector.
// Assumes positive widths; group count rounds up so no input bit is dropped.
package ooon_pkg;

    // Number of groups needed to cover total_w bits in slices of grp_w bits.
    function automatic int groups_for(input int total_w, input int grp_w);
        return (total_w + grp_w - 1) / grp_w;
    endfunction

    // Width of the zero-padded bus that the groups cover.
    function automatic int padded_width(input int total_w, input int grp_w);
        return groups_for(total_w, grp_w) * grp_w;
    endfunction

endpackage

// File: rtl/ooon_group_cls.sv
// Module: ooon_group_cls
// Classifies a W-bit slice as idle, single or crowded. It reports single on
// `one` and crowded on `many`; idle is the state with neither flag set.
// Assumes W >= 1. Combinational; a linear scan keeps "seen" and "seen twice".
module ooon_group_cls #(
    parameter int W = 10
) (
    input  logic [W-1:0] bits,
    output logic         one,
    output logic         many
);

    logic seen;
    logic dup;

    // Scan the slice and track whether a 1 was found and whether a second one followed.
    always_comb begin
        seen = 1'b0;
        dup  = 1'b0;
        for (int i = 0; i < W; i++) begin
            dup  = dup | (seen & bits[i]);
            seen = seen | bits[i];
        end
    end

    // Map the scan result onto the two group flags.
    always_comb begin
        one  = seen & ~dup;
        many = dup;
    end

    // Guard the flags against a population count of the slice.
    always_comb begin
        AST_FLAGS_EXCLUSIVE: assert (!(one && many));                       // R4
        AST_ONE_IS_SINGLE:   assert (one == ($countones(bits) == 1));       // R4
        AST_MANY_IS_CROWD:   assert (many == ($countones(bits) > 1));       // R4
    end

endmodule

// File: rtl/ooon_any_reduce.sv
// Module: ooon_any_reduce
// Reports whether any bit of a W-bit flag vector is set. It is used to collect
// the per-group crowded flags. Assumes W >= 1. Combinational.
module ooon_any_reduce #(
    parameter int W = 9
) (
    input  logic [W-1:0] flags,
    output logic         any_set
);

    // OR-reduce the flag vector.
    always_comb begin
        any_set = |flags;
    end

endmodule

// File: rtl/one_hot_detect.sv
// Module: one_hot_detect
// Two-level detector: first-level units classify M-bit groups of the
// zero-padded bus. A second-level classifier counts the single groups, and an
// OR collects the crowded groups. The output is high for exactly one single
// group and no crowded group. Assumes N >= 1 and M >= 1. Combinational.
module one_hot_detect #(
    parameter int N = 90,
    parameter int M = 10
) (
    input  logic [N-1:0]                           din,
    output logic [ooon_pkg::groups_for(N, M)-1:0]  grp_one,
    output logic [ooon_pkg::groups_for(N, M)-1:0]  grp_many,
    output logic                                   exactly_one
);

    localparam int G    = ooon_pkg::groups_for(N, M);
    localparam int PADW = ooon_pkg::padded_width(N, M);

    logic [PADW-1:0] padded;
    logic            s2_single;
    logic            s2_multi;
    logic            s2_crowd;

    // Zero-extend the bus so the last group is full width.
    always_comb begin
        padded = PADW'(din);
    end

    // First level: one classifier per group.
    for (genvar g = 0; g < G; g++) begin : g_grp
        ooon_group_cls #(.W(M)) u_grp (
            .bits (padded[g*M +: M]),
            .one  (grp_one[g]),
            .many (grp_many[g])
        );
    end

    // Second level: classify the single flags themselves.
    ooon_group_cls #(.W(G)) u_s2_single (
        .bits (grp_one),
        .one  (s2_single),
        .many (s2_multi)
    );

    // Second level: any crowded group.
    ooon_any_reduce #(.W(G)) u_s2_crowd (
        .flags   (grp_many),
        .any_set (s2_crowd)
    );

    // Final decision from the two second-level units.
    always_comb begin
        exactly_one = s2_single & ~s2_crowd;
    end

    // Guard the result against the whole-bus population count and the stage rules.
    always_comb begin
        AST_OUT_MATCHES_COUNT: assert (exactly_one == ($countones(din) == 1));   // R1
        AST_IDLE_BUS_LOW:      assert (!((din == '0) && exactly_one));           // R2
        AST_MULTI_SINGLE_LOW:  assert (!(s2_multi && exactly_one));              // R5
        AST_CROWD_FORCES_LOW:  assert (!((grp_many != '0) && exactly_one));      // R6
        AST_PAD_NEVER_CROWDS:  assert ($countones(grp_many) <= $countones(din) / 2); // R7
    end

endmodule

// File: tb/one_hot_detect_test.sv
// Bench: directed scenarios, one task each, checked against population counts.
module one_hot_detect_test;

    localparam int N  = 90;
    localparam int M  = 10;
    localparam int G  = (N + M - 1) / M;
    localparam int PN = 25;
    localparam int PG = (PN + M - 1) / M;

    logic          clk = 1'b0;
    logic [N-1:0]  din = '0;
    logic [G-1:0]  grp_one;
    logic [G-1:0]  grp_many;
    logic          exactly_one;
    logic [PN-1:0] pdin = '0;
    logic [PG-1:0] pgrp_one;
    logic [PG-1:0] pgrp_many;
    logic          pexactly_one;
    int            checks = 0;
    int            errors = 0;

    always #10 clk = ~clk;

    one_hot_detect #(.N(N), .M(M)) uut (
        .din(din), .grp_one(grp_one), .grp_many(grp_many), .exactly_one(exactly_one)
    );

    one_hot_detect #(.N(PN), .M(M)) uut_pad (
        .din(pdin), .grp_one(pgrp_one), .grp_many(pgrp_many), .exactly_one(pexactly_one)
    );

    // Apply one vector to the main instance and check output and group flags.
    task automatic apply_check(input logic [N-1:0] v, input string rq);
        logic exp;
        @(negedge clk);
        din = v;
        #5;
        exp = ($countones(v) == 1);
        checks++;
        if (exactly_one !== exp) begin
            errors++;
            $display("FAIL %s exactly_one=%0b expected=%0b vec=%h", rq, exactly_one, exp, v);
        end
        for (int g = 0; g < G; g++) begin
            int cnt;
            cnt = $countones(v[g*M +: M]);
            checks++;
            if (grp_one[g] !== (cnt == 1) || grp_many[g] !== (cnt > 1)) begin
                errors++;
                $display("FAIL R4 group %0d one=%0b many=%0b expected one=%0b many=%0b",
                         g, grp_one[g], grp_many[g], cnt == 1, cnt > 1);
            end
        end
    endtask

    // R2: idle bus, all flags low.
    task automatic t_idle();
        apply_check('0, "R2");
        checks++;
        if (grp_one !== '0 || grp_many !== '0) begin
            errors++;
            $display("FAIL R2 grp_one=%h grp_many=%h expected 0 0", grp_one, grp_many);
        end
    endtask

    // R1: every single position.
    task automatic t_onehot();
        for (int i = 0; i < N; i++) apply_check(N'(1) << i, "R1");
    endtask

    // R3: pairs inside one group.
    task automatic t_pair_within();
        for (int g = 0; g < G; g++) begin
            apply_check((N'(1) << (g*M)) | (N'(1) << (g*M + M - 1)), "R3");
            apply_check((N'(3) << (g*M + 4)), "R3");
        end
        apply_check({N{1'b1}}, "R3");
    endtask

    // R5: single 1s in separate groups.
    task automatic t_pair_across();
        for (int g = 0; g + 1 < G; g++)
            apply_check((N'(1) << (g*M + 2)) | (N'(1) << ((g+1)*M + 7)), "R5");
        apply_check((N'(1) << 0) | (N'(1) << (N-1)), "R5");
    endtask

    // R6: one single group together with one crowded group.
    task automatic t_mixed();
        apply_check((N'(1) << 3) | (N'(3) << 40), "R6");
        apply_check((N'(7) << 80) | (N'(1) << 15), "R6");
    endtask

    // R1: sparse random vectors of one to three bits, plus dense ones.
    task automatic t_random();
        for (int k = 0; k < 200; k++) begin
            logic [N-1:0] v;
            v = '0;
            for (int b = 0; b < 1 + (k % 3); b++) v[$urandom_range(N-1, 0)] = 1'b1;
            apply_check(v, "R1");
        end
        for (int k = 0; k < 20; k++) begin
            logic [N-1:0] v;
            v = {$urandom(), $urandom(), $urandom()};
            apply_check(v, "R1");
        end
    endtask

    // R7: partial last group on the N=25 instance.
    task automatic t_padded();
        for (int i = 0; i < PN; i++) begin
            @(negedge clk);
            pdin = PN'(1) << i;
            #5;
            checks++;
            if (pexactly_one !== 1'b1 || pgrp_one[i / M] !== 1'b1 || pgrp_many !== '0) begin
                errors++;
                $display("FAIL R7 bit %0d out=%0b one=%b many=%b expected out=1", i,
                         pexactly_one, pgrp_one, pgrp_many);
            end
        end
        @(negedge clk);
        pdin = (PN'(1) << 24) | (PN'(1) << 20);
        #5;
        checks++;
        if (pexactly_one !== 1'b0 || pgrp_many !== 3'b100) begin
            errors++;
            $display("FAIL R7 last-group pair out=%0b many=%b expected out=0 many=100",
                     pexactly_one, pgrp_many);
        end
        @(negedge clk);
        pdin = '0;
        #5;
        checks++;
        if (pexactly_one !== 1'b0 || pgrp_one !== '0 || pgrp_many !== '0) begin
            errors++;
            $display("FAIL R7 idle out=%0b one=%b many=%b expected all 0",
                     pexactly_one, pgrp_one, pgrp_many);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Scenario sequence.
    initial begin
        t_idle();
        t_onehot();
        t_pair_within();
        t_pair_across();
        t_mixed();
        t_random();
        t_padded();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule